// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block drives an external successive-approximation analog core through its sample and conversion phases. Software picks an input channel, a clock source, a clock divider, a sample-time setting, a resolution and a one-shot or repeating mode. Writing a channel code starts a conversion. The block then counts the sample phase and the conversion phase in ADC clock ticks. When the conversion phase ends, it takes the core's right-justified result and raises a one-cycle done strobe.

The ADC clock is a tick enable in the bus clock domain. It is formed from the bus clock, from the bus clock halved, or from an already-synchronized asynchronous tick input, and is then divided by 1, 2, 4 or 8. The prescaler restarts whenever a conversion is started, so the phase timing is fixed from the triggering write. Channel code 31 is reserved as "no conversion": writing it halts any activity and starts nothing. Writing any other code while busy aborts the conversion in progress and starts again on the new channel.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, active_o, done_o, sample_o and convert_o are low and result_o is zero. The configuration resets to: bus clock, divide by 1, short sample, select 0, 8-bit, one-shot.
- R2: A ctrl_we_i write with chan_i other than 31 makes active_o and sample_o high in the next cycle, with chan_o equal to the written code.
- R3: The ADC tick is derived from the source selected by cfg_src_i. Code 0 ticks every bus cycle. Code 1 ticks every second bus cycle. Code 3 ticks once per sampled async_tick_i pulse. Code 2 never ticks, so a conversion started under it never finishes. The tick is then divided by 2^cfg_div_i. The prescaler restarts at every start.
- R4: With cfg_long_i = 0, the sample phase lasts 2, 4, 6 or 8 ADC ticks for cfg_smp_i = 0, 1, 2 or 3.
- R5: With cfg_long_i = 1, the sample phase lasts 12, 16, 20 or 24 ADC ticks for cfg_smp_i = 0, 1, 2 or 3.
- R6: The conversion phase lasts resolution+1 ADC ticks. cfg_res_i codes 0, 1 and 2 select 8, 10 and 12 bits; code 3 acts as 12 bits. done_o therefore rises in the bus cycle right after the bus edge that carries the (sample+conversion)-th ADC tick.
- R7: done_o is a single-cycle pulse. In that same cycle result_o holds core_data_i with every bit at or above the resolution cleared. result_o changes at no other time.
- R8: In one-shot mode (cfg_cont_i = 0), active_o is already low in the cycle in which done_o is high.
- R9: In continuous mode (cfg_cont_i = 1), a new sample phase starts at completion without a write. active_o stays high, and the next done_o follows after the same number of cycles.
- R10: Writing chan_i = 31 starts nothing when idle. When busy, it drops active_o in the next cycle and suppresses the pending done_o.
- R11: Writing a non-31 code while active restarts the sample phase on the new channel. The timing is counted afresh from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| async_tick_i | input | 1 | Synchronized asynchronous clock tick, one bus cycle wide |
| cfg_we_i | input | 1 | Load the configuration fields |
| cfg_src_i | input | 2 | Clock source: 0 bus, 1 bus/2, 2 unused, 3 async |
| cfg_div_i | input | 2 | ADC clock divide by 2^value |
| cfg_long_i | input | 1 | Long sample-time table |
| cfg_smp_i | input | 2 | Sample-time select |
| cfg_res_i | input | 2 | Resolution: 0 8-bit, 1 10-bit, 2/3 12-bit |
| cfg_cont_i | input | 1 | Continuous conversions |
| ctrl_we_i | input | 1 | Channel write strobe (starts, restarts or stops) |
| chan_i | input | 5 | Channel code, 31 = disabled |
| core_data_i | input | 12 | Right-justified result from the analog core |
| chan_o | output | 5 | Channel presented to the core |
| sample_o | output | 1 | Sample phase in progress |
| convert_o | output | 1 | Conversion phase in progress |
| active_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 12 | Masked captured result |

## Verification
The bench times each conversion from the triggering write to the done strobe, across random sources, dividers, sample tables and resolutions. A wrong table entry or an off-by-one in either phase counter therefore shows up as a cycle-count mismatch. With the asynchronous source it counts the tick pulses actually delivered, which catches a prescaler that also counts the pulse on the start edge. Directed cases cover channel 31 both while idle and mid-conversion, where a broken decode would start a conversion or still deliver a strobe. They also cover a restart part-way through, where a design that does not clear its counters finishes early, the stalled unused clock source, and continuous mode, where a design that drops to idle would miss the second strobe. Result masking per resolution is checked against random core data, so unmasked upper bits are caught.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CHAN_W   = 5;
  localparam int DATA_W   = 12;
  localparam int SEL_W    = 2;
  localparam int PH_CNT_W = 5;
  localparam int MIN_RES  = 8;

  typedef enum logic [1:0] {
    SRC_BUS      = 2'd0,
    SRC_BUS_HALF = 2'd1,
    SRC_NONE     = 2'd2,
    SRC_ASYNC    = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_CONVERT = 2'd2
  } phase_e;

  typedef struct packed {
    clk_src_e         src;
    logic [SEL_W-1:0] div;
    logic             long_smp;
    logic [SEL_W-1:0] smp;
    logic [1:0]       res;
    logic             cont;
  } cfg_t;
endpackage

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler
  import adc_seq_pkg::*;
#(
  parameter int DIV_SEL_W = SEL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  clk_src_e             src_i,
  input  logic [DIV_SEL_W-1:0] div_i,
  input  logic                 async_tick_i,
  output logic                 tick_o
);
  localparam int CNT_W = (1 << DIV_SEL_W) - 1;

  logic             half_q;
  logic [CNT_W-1:0] div_cnt_q;
  logic [CNT_W-1:0] div_lim;
  logic             src_tick;

  assign div_lim = CNT_W'((1 << div_i) - 1);

  always_comb begin
    unique case (src_i)
      SRC_BUS:      src_tick = 1'b1;
      SRC_BUS_HALF: src_tick = half_q;
      SRC_ASYNC:    src_tick = async_tick_i;
      default:      src_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q    <= 1'b0;
      div_cnt_q <= '0;
    end else if (clr_i) begin
      half_q    <= 1'b0;
      div_cnt_q <= '0;
    end else begin
      half_q <= ~half_q;
      if (src_tick) begin
        div_cnt_q <= (div_cnt_q == div_lim) ? '0 : div_cnt_q + 1'b1;
      end
    end
  end

  assign tick_o = ~clr_i & src_tick & (div_cnt_q == div_lim);
endmodule

// File: rtl/adc_phase_len.sv
module adc_phase_len
  import adc_seq_pkg::*;
#(
  parameter int SMP_SEL_W = SEL_W,
  parameter int CNT_W     = PH_CNT_W,
  parameter int RES_W     = DATA_W,
  parameter int RES_MIN   = MIN_RES,
  parameter int RB_W      = $clog2(RES_W + 1)
) (
  input  logic                 long_i,
  input  logic [SMP_SEL_W-1:0] smp_i,
  input  logic [1:0]           res_i,
  output logic [CNT_W-1:0]     smp_len_o,
  output logic [CNT_W-1:0]     conv_len_o,
  output logic [RB_W-1:0]      res_bits_o
);
  localparam int SHORT_STEP = 2;
  localparam int LONG_BASE  = 12;
  localparam int LONG_STEP  = 4;
  localparam int RES_STEP   = 2;

  int sel_v;
  int bits_v;

  always_comb begin
    sel_v = int'(smp_i);
    if (long_i) smp_len_o = CNT_W'(LONG_BASE + LONG_STEP * sel_v);
    else        smp_len_o = CNT_W'(SHORT_STEP * (sel_v + 1));
    bits_v = RES_MIN + RES_STEP * int'(res_i);
    if (bits_v > RES_W) bits_v = RES_W;
    res_bits_o = RB_W'(bits_v);
    conv_len_o = CNT_W'(bits_v + 1);
  end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_seq_pkg::*;
#(
  parameter int RES_W = DATA_W,
  parameter int RB_W  = $clog2(RES_W + 1)
) (
  input  logic [RES_W-1:0] raw_i,
  input  logic [RB_W-1:0]  bits_i,
  output logic [RES_W-1:0] data_o
);
  for (genvar g = 0; g < RES_W; g++) begin : g_bit
    assign data_o[g] = raw_i[g] & (RB_W'(g) < bits_i);
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = CHAN_W,
  parameter int RES_W = DATA_W,
  parameter int CNT_W = PH_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             async_tick_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_src_i,
  input  logic [1:0]       cfg_div_i,
  input  logic             cfg_long_i,
  input  logic [1:0]       cfg_smp_i,
  input  logic [1:0]       cfg_res_i,
  input  logic             cfg_cont_i,
  input  logic             ctrl_we_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [RES_W-1:0] core_data_i,
  output logic [CH_W-1:0]  chan_o,
  output logic             sample_o,
  output logic             convert_o,
  output logic             active_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int               RB_W   = $clog2(RES_W + 1);
  localparam logic [CH_W-1:0]  CH_OFF = '1;

  cfg_t             cfg_q;
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  chan_q;
  logic [RES_W-1:0] result_q;
  logic             done_q;

  logic             start, stop, clr, tick;
  logic [CNT_W-1:0] smp_len, conv_len;
  logic [RB_W-1:0]  res_bits;
  logic [RES_W-1:0] masked;

  assign start = ctrl_we_i & (chan_i != CH_OFF);
  assign stop  = ctrl_we_i & (chan_i == CH_OFF);
  assign clr   = (ph_q == PH_IDLE) | ctrl_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{src: SRC_BUS, div: '0, long_smp: 1'b0, smp: '0, res: '0, cont: 1'b0};
    end else if (cfg_we_i) begin
      cfg_q <= '{src: clk_src_e'(cfg_src_i), div: cfg_div_i, long_smp: cfg_long_i,
                 smp: cfg_smp_i, res: cfg_res_i, cont: cfg_cont_i};
    end
  end

  adc_clk_prescaler #(.DIV_SEL_W(SEL_W)) u_presc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .src_i       (cfg_q.src),
    .div_i       (cfg_q.div),
    .async_tick_i(async_tick_i),
    .tick_o      (tick)
  );

  adc_phase_len #(.SMP_SEL_W(SEL_W), .CNT_W(CNT_W), .RES_W(RES_W), .RES_MIN(MIN_RES), .RB_W(RB_W)) u_len (
    .long_i    (cfg_q.long_smp),
    .smp_i     (cfg_q.smp),
    .res_i     (cfg_q.res),
    .smp_len_o (smp_len),
    .conv_len_o(conv_len),
    .res_bits_o(res_bits)
  );

  adc_result_fmt #(.RES_W(RES_W), .RB_W(RB_W)) u_fmt (
    .raw_i (core_data_i),
    .bits_i(res_bits),
    .data_o(masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      chan_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (stop) begin
        ph_q  <= PH_IDLE;
        cnt_q <= '0;
      end else if (start) begin
        ph_q   <= PH_SAMPLE;
        cnt_q  <= '0;
        chan_q <= chan_i;
      end else if (tick) begin
        unique case (ph_q)
          PH_SAMPLE: begin
            if (cnt_q == smp_len - 1'b1) begin
              ph_q  <= PH_CONVERT;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_CONVERT: begin
            if (cnt_q == conv_len - 1'b1) begin
              result_q <= masked;
              done_q   <= 1'b1;
              ph_q     <= cfg_q.cont ? PH_SAMPLE : PH_IDLE;
              cnt_q    <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: cnt_q <= '0;
        endcase
      end
    end
  end

  assign chan_o    = chan_q;
  assign sample_o  = (ph_q == PH_SAMPLE);
  assign convert_o = (ph_q == PH_CONVERT);
  assign active_o  = (ph_q != PH_IDLE);
  assign done_o    = done_q;
  assign result_o  = result_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CH_W  = 5,
  parameter int RES_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic [CH_W-1:0]  chan_i,
  input logic             cont_i,
  input logic [CH_W-1:0]  chan_o,
  input logic             sample_o,
  input logic             convert_o,
  input logic             active_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o
);
  // R2
  start_enters_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && chan_i != '1) |=> (active_o && sample_o && chan_o == $past(chan_i)));

  // R10
  off_code_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && chan_i == '1) |=> (!active_o && !done_o));

  // R7
  done_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R8
  oneshot_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cont_i) |-> !active_o);

  // R9
  cont_resample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cont_i) |-> sample_o);

  // R2
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && convert_o));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctrl_we_i(ctrl_we_i),
  .chan_i   (chan_i),
  .cont_i   (cfg_q.cont),
  .chan_o   (chan_o),
  .sample_o (sample_o),
  .convert_o(convert_o),
  .active_o (active_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        async_tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_src = '0, cfg_div = '0, cfg_smp = '0, cfg_res = '0;
  logic        cfg_long = 1'b0, cfg_cont = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [4:0]  chan = '0;
  logic [11:0] core_data = '0;
  logic [4:0]  chan_o;
  logic        sample_o, convert_o, active_o, done_o;
  logic [11:0] result_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .async_tick_i(async_tick),
    .cfg_we_i(cfg_we), .cfg_src_i(cfg_src), .cfg_div_i(cfg_div), .cfg_long_i(cfg_long),
    .cfg_smp_i(cfg_smp), .cfg_res_i(cfg_res), .cfg_cont_i(cfg_cont),
    .ctrl_we_i(ctrl_we), .chan_i(chan), .core_data_i(core_data),
    .chan_o(chan_o), .sample_o(sample_o), .convert_o(convert_o),
    .active_o(active_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int smp_ticks(input bit lng, input int sel);
    return lng ? 12 + 4 * sel : 2 * (sel + 1);
  endfunction

  function automatic int res_bits(input int r);
    return (r >= 2) ? 12 : 8 + 2 * r;
  endfunction

  function automatic int bus_per_tick(input int src, input int div);
    return ((src == 1) ? 2 : 1) << div;
  endfunction

  task automatic set_cfg(input int src, input int div, input bit lng, input int smp,
                         input int res, input bit cont);
    @(negedge clk);
    cfg_src = 2'(src); cfg_div = 2'(div); cfg_long = lng;
    cfg_smp = 2'(smp); cfg_res = 2'(res); cfg_cont = cont; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_chan(input logic [4:0] c);
    @(negedge clk);
    chan = c; ctrl_we = 1'b1; async_tick = 1'b0;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  // Starts a conversion; returns bus edges to done, delivered async ticks, last-edge tick flag
  task automatic run_conv(input logic [4:0] c, output int edges, output int aticks,
                          output bit last_tick, output bit active_ok);
    int k;
    write_chan(c);
    chk(active_o && sample_o && chan_o == c, "R2 start", int'(chan_o), int'(c));
    k = 0; aticks = 0; last_tick = 1'b0; active_ok = 1'b1;
    while (!done_o && k < 4000) begin
      async_tick = (k % 3 == 2);
      if (async_tick) aticks++;
      last_tick = async_tick;
      @(negedge clk);
      k++;
      if (!done_o && !active_o) active_ok = 1'b0;
    end
    async_tick = 1'b0;
    edges = k;
  endtask

  initial begin
    int edges, aticks, exp_t, exp_r, src, div, smp, res, n;
    bit lng, lt, aok;
    void'($urandom(32'h5eed_0a1c));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!active_o && !done_o && !sample_o && !convert_o, "R1 idle outputs", int'(active_o), 0);
    chk(result_o == '0, "R1 result", int'(result_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset config: bus, /1, short sel0, 8-bit -> (2+9) edges
    core_data = 12'hfff;
    run_conv(5'd4, edges, aticks, lt, aok);
    chk(edges == 11, "R1 default timing", edges, 11);
    chk(result_o == 12'h0ff, "R7 8-bit mask", int'(result_o), 12'h0ff);
    chk(!active_o, "R8 oneshot idle at done", int'(active_o), 0);
    @(negedge clk);
    chk(!done_o, "R7 pulse width", int'(done_o), 0);

    // Random configurations
    for (int i = 0; i < 28; i++) begin
      int pick;
      pick = int'($urandom_range(0, 2));
      src  = (pick == 2) ? 3 : pick;
      div  = int'($urandom_range(0, 3));
      lng  = 1'($urandom_range(0, 1));
      smp  = int'($urandom_range(0, 3));
      res  = int'($urandom_range(0, 3));
      set_cfg(src, div, lng, smp, res, 1'b0);
      core_data = 12'($urandom);
      run_conv(5'($urandom_range(0, 30)), edges, aticks, lt, aok);
      exp_t = smp_ticks(lng, smp) + res_bits(res) + 1;
      if (src == 3) begin
        chk(aticks == exp_t * (1 << div) && lt, "R3 async tick count", aticks, exp_t * (1 << div));
      end else begin
        chk(edges == exp_t * bus_per_tick(src, div),
            lng ? "R5 long sample timing" : "R4 short sample timing",
            edges, exp_t * bus_per_tick(src, div));
      end
      exp_r = int'(core_data) & ((1 << res_bits(res)) - 1);
      chk(int'(result_o) == exp_r, "R6 R7 resolution mask", int'(result_o), exp_r);
      chk(aok && !active_o, "R8 active span", int'(active_o), 0);
      @(negedge clk);
      chk(!done_o && result_o == 12'(exp_r), "R7 pulse and hold", int'(done_o), 0);
    end

    // R10 off code while idle
    set_cfg(0, 0, 1'b0, 0, 0, 1'b0);
    write_chan(5'd31);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (active_o || done_o) n++;
      @(negedge clk);
    end
    chk(n == 0, "R10 idle off code", n, 0);

    // R10 abort mid-conversion
    set_cfg(0, 1, 1'b1, 3, 2, 1'b0);
    write_chan(5'd9);
    repeat (20) @(negedge clk);
    write_chan(5'd31);
    chk(!active_o, "R10 abort", int'(active_o), 0);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      if (done_o) n++;
      @(negedge clk);
    end
    chk(n == 0, "R10 no done after abort", n, 0);

    // R11 restart mid-conversion
    set_cfg(0, 1, 1'b0, 2, 1, 1'b0);
    write_chan(5'd2);
    repeat (9) @(negedge clk);
    run_conv(5'd17, edges, aticks, lt, aok);
    exp_t = (6 + 11) * 2;
    chk(edges == exp_t, "R11 restart timing", edges, exp_t);
    chk(chan_o == 5'd17, "R11 new channel", int'(chan_o), 17);

    // R3 unused source stalls
    set_cfg(2, 0, 1'b0, 0, 0, 1'b0);
    write_chan(5'd1);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      if (done_o || !active_o) n++;
      @(negedge clk);
    end
    chk(n == 0, "R3 unused source stalls", n, 0);
    write_chan(5'd31);
    chk(!active_o, "R10 stop stalled", int'(active_o), 0);

    // R9 continuous
    set_cfg(0, 0, 1'b0, 1, 2, 1'b1);
    core_data = 12'habc;
    run_conv(5'd5, edges, aticks, lt, aok);
    chk(edges == 17, "R9 first period", edges, 17);
    chk(active_o && sample_o, "R9 stays active", int'(active_o), 1);
    n = 0;
    @(negedge clk);
    n = 1;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == 17, "R9 second period", n, 17);
    chk(result_o == 12'habc, "R9 R7 result", int'(result_o), 12'habc);
    write_chan(5'd31);
    chk(!active_o, "R10 stop continuous", int'(active_o), 0);

    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule